// File: doc/BRIEF.md
# Block-Transfer Data Channel

This block is a small byte channel that carries bulk data between a host processor and a second (parasite) processor. Each processor sees two byte-wide registers through its own port: a status register at offset 0 and a data register at offset 1. A direction input decides which side produces bytes and which side consumes them. A one-bit depth input selects whether the channel buffers one byte or two before it counts as full.

The channel raises a non-maskable transfer request toward the parasite. When the host feeds the parasite, the request rises once the host has filled the buffer to the chosen depth. When the parasite feeds the host, the request rises once the host has drained the buffer to empty. The parasite services the request by moving one or two bytes, matching the depth. Its first data-register access drops the request. Changing the depth or the direction throws away any buffered bytes and drops the request.

Top module: `bt_xfer_chan`

## Requirements
- R1: After reset the buffer is empty, the depth is one byte and `nmi_o` is low, so a status read returns 0x40.
- R2: A status read (offset 0, on either port) returns bit 7 = buffer holds at least one byte and bit 6 = buffer holds fewer bytes than the current depth, with bits 5:0 zero. A status read has no side effect.
- R3: `cfg_wide_i` = 0 gives a depth of one byte and `cfg_wide_i` = 1 gives a depth of two. A write to a full buffer is dropped.
- R4: With `cfg_dir_i` = 0 the host writes and the parasite reads. With `cfg_dir_i` = 1 the roles swap. A data write from the reading side is ignored. A data read from the writing side returns 0x00 and removes nothing.
- R5: Bytes are read out in the order they were accepted. A data read of an empty buffer returns 0x00 and changes nothing. A port's read data is 0x00 whenever that port's select and read strobe are not both high.
- R6: With `cfg_dir_i` = 0, `nmi_o` rises on the clock edge at which an accepted host write brings the byte count up to the depth.
- R7: With `cfg_dir_i` = 1, `nmi_o` rises on the clock edge at which an accepted host read leaves the buffer empty.
- R8: `nmi_o` falls on the edge that ends a cycle with a parasite data-register access (read or write at offset 1). A parasite status read leaves it set. A set event in the same cycle wins.
- R9: In any cycle where `cfg_wide_i` or `cfg_dir_i` differs from the value held since the previous edge, the buffer is flushed, `nmi_o` is cleared and all accesses in that cycle are ignored.
- R10: A write and a read in the same cycle both take effect when the byte count at the start of that cycle allows each of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wide_i | input | 1 | Depth select: 0 = one byte, 1 = two bytes |
| cfg_dir_i | input | 1 | Direction: 0 = host to parasite, 1 = parasite to host |
| h_sel_i | input | 1 | Host port select |
| h_ofs_i | input | 1 | Host register offset: 0 = status, 1 = data |
| h_rd_i | input | 1 | Host read strobe |
| h_wr_i | input | 1 | Host write strobe |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data |
| p_sel_i | input | 1 | Parasite port select |
| p_ofs_i | input | 1 | Parasite register offset: 0 = status, 1 = data |
| p_rd_i | input | 1 | Parasite read strobe |
| p_wr_i | input | 1 | Parasite write strobe |
| p_wdata_i | input | 8 | Parasite write data |
| p_rdata_o | output | 8 | Parasite read data |
| nmi_o | output | 1 | Non-maskable transfer request to the parasite |

## Verification
The assertions assume that neither port raises its read and write strobes in the same cycle. They also assume that both configuration inputs change only between clock edges, so a change is seen as one flush cycle. The stimulus drives every input just after the falling edge, gives each side at most one strobe per cycle, and changes the depth and direction only rarely. This lets fill, drain and request behaviour build up between flushes.

// File: rtl/bt_chan_pkg.sv
`timescale 1ns/1ps
package bt_chan_pkg;

  typedef enum logic {
    DIR_H2P = 1'b0,
    DIR_P2H = 1'b1
  } xfer_dir_e;

  localparam logic OFS_STAT = 1'b0;
  localparam logic OFS_DATA = 1'b1;

  localparam int SIDE_HOST = 0;
  localparam int SIDE_PARA = 1;
  localparam int N_SIDES   = 2;

  // status byte: [7] occupied, [6] room left, rest zero
  function automatic logic [7:0] mk_status(input logic occupied, input logic room);
    return {occupied, room, 6'b00_0000};
  endfunction

endpackage

// File: rtl/bt_rst_sync.sv
`timescale 1ns/1ps
module bt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bt_fifo.sv
`timescale 1ns/1ps
module bt_fifo #(
  parameter  int DW        = 8,
  parameter  int MAX_DEPTH = 2,
  localparam int CW        = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] depth,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] wdata,
  output logic          push_acc,
  output logic          pop_acc,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);

  localparam int PW = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam logic [PW-1:0] LAST_IDX = PW'(MAX_DEPTH - 1);

  logic [DW-1:0] mem_q [MAX_DEPTH];
  logic [PW-1:0] rptr_q, rptr_d;
  logic [PW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] cnt_q,  cnt_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    push_acc = push_req && !flush && (cnt_q < depth);
    pop_acc  = pop_req  && !flush && (cnt_q != '0);
    rptr_d   = rptr_q;
    wptr_d   = wptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_acc) wptr_d = ptr_inc(wptr_q);
      if (pop_acc)  rptr_d = ptr_inc(rptr_q);
      cnt_d = cnt_q + CW'(push_acc) - CW'(pop_acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (push_acc) begin
      mem_q[wptr_q] <= wdata;
    end
  end

  assign head      = mem_q[rptr_q];
  assign count     = cnt_q;
  assign count_nxt = cnt_d;

  // R3
  cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= depth);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/bt_nmi_gen.sv
`timescale 1ns/1ps
module bt_nmi_gen
  import bt_chan_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  xfer_dir_e     dir,
  input  logic [CW-1:0] depth,
  input  logic          push_acc,
  input  logic          pop_acc,
  input  logic [CW-1:0] count_nxt,
  input  logic          para_acc,
  output logic          nmi
);

  logic nmi_q, nmi_d;
  logic set_evt;

  always_comb begin
    if (dir == DIR_H2P) begin
      set_evt = push_acc && (count_nxt == depth);
    end else begin
      set_evt = pop_acc && (count_nxt == '0);
    end
    set_evt = set_evt && !flush;

    nmi_d = nmi_q;
    if (flush) begin
      nmi_d = 1'b0;
    end else if (set_evt) begin
      nmi_d = 1'b1;
    end else if (para_acc) begin
      nmi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
    end else begin
      nmi_q <= nmi_d;
    end
  end

  assign nmi = nmi_q;

  // R6 R7
  nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_q) |-> $past(push_acc || pop_acc));

  // R8
  nmi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_q) |-> $past(para_acc || flush));

  // R9
  flush_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !nmi_q);

endmodule

// File: rtl/bt_port_dec.sv
`timescale 1ns/1ps
module bt_port_dec
  import bt_chan_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          sel,
  input  logic          ofs,
  input  logic          rd,
  input  logic          wr,
  input  logic          is_writer,
  input  logic [7:0]    status,
  input  logic [DW-1:0] head,
  input  logic          nonempty,
  output logic          push_req,
  output logic          pop_req,
  output logic [DW-1:0] rdata
);

  logic data_hit;

  always_comb begin
    data_hit = sel && (ofs == OFS_DATA);
    push_req = data_hit && wr && is_writer;
    pop_req  = data_hit && rd && !is_writer;
    rdata    = '0;
    if (sel && rd) begin
      if (ofs == OFS_STAT) begin
        rdata = DW'(status);
      end else if (!is_writer && nonempty) begin
        rdata = head;
      end
    end
  end

endmodule

// File: rtl/bt_xfer_chan.sv
`timescale 1ns/1ps
module bt_xfer_chan
  import bt_chan_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide_i,
  input  logic          cfg_dir_i,
  input  logic          h_sel_i,
  input  logic          h_ofs_i,
  input  logic          h_rd_i,
  input  logic          h_wr_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  input  logic          p_sel_i,
  input  logic          p_ofs_i,
  input  logic          p_rd_i,
  input  logic          p_wr_i,
  input  logic [DW-1:0] p_wdata_i,
  output logic [DW-1:0] p_rdata_o,
  output logic          nmi_o
);

  localparam int CW = $clog2(MAX_DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_NARROW = CW'(1);
  localparam logic [CW-1:0] DEPTH_WIDE   = CW'(MAX_DEPTH);

  logic      srst_n;
  logic      wide_q, wide_d;
  xfer_dir_e dir_q,  dir_d;
  logic      flush;
  logic [CW-1:0] depth;

  logic          push_req, pop_req, push_acc, pop_acc;
  logic [DW-1:0] fifo_wdata, fifo_head;
  logic [CW-1:0] fifo_cnt, fifo_cnt_nxt;
  logic [7:0]    status;
  logic          para_acc;

  logic [N_SIDES-1:0] s_sel, s_ofs, s_rd, s_wr, s_push, s_pop;
  logic [DW-1:0]      s_rdata [N_SIDES];

  bt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // configuration capture; a mismatch is a flush cycle
  always_comb begin
    flush  = (cfg_wide_i != wide_q) || (xfer_dir_e'(cfg_dir_i) != dir_q);
    wide_d = wide_q;
    dir_d  = dir_q;
    if (flush) begin
      wide_d = cfg_wide_i;
      dir_d  = xfer_dir_e'(cfg_dir_i);
    end
    depth = wide_q ? DEPTH_WIDE : DEPTH_NARROW;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wide_q <= 1'b0;
      dir_q  <= DIR_H2P;
    end else begin
      wide_q <= wide_d;
      dir_q  <= dir_d;
    end
  end

  assign s_sel = {p_sel_i, h_sel_i};
  assign s_ofs = {p_ofs_i, h_ofs_i};
  assign s_rd  = {p_rd_i,  h_rd_i};
  assign s_wr  = {p_wr_i,  h_wr_i};

  assign status = mk_status(fifo_cnt != '0, fifo_cnt < depth);

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic is_wr;
    assign is_wr = (dir_q == DIR_H2P) ? (s == SIDE_HOST) : (s == SIDE_PARA);

    bt_port_dec #(.DW(DW)) u_dec (
      .sel       (s_sel[s]),
      .ofs       (s_ofs[s]),
      .rd        (s_rd[s]),
      .wr        (s_wr[s]),
      .is_writer (is_wr),
      .status    (status),
      .head      (fifo_head),
      .nonempty  (fifo_cnt != '0),
      .push_req  (s_push[s]),
      .pop_req   (s_pop[s]),
      .rdata     (s_rdata[s])
    );
  end

  always_comb begin
    push_req   = |s_push;
    pop_req    = |s_pop;
    fifo_wdata = (dir_q == DIR_H2P) ? h_wdata_i : p_wdata_i;
    para_acc   = p_sel_i && (p_ofs_i == OFS_DATA) && (p_rd_i || p_wr_i);
  end

  bt_fifo #(.DW(DW), .MAX_DEPTH(MAX_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (srst_n),
    .flush     (flush),
    .depth     (depth),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .wdata     (fifo_wdata),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .count_nxt (fifo_cnt_nxt)
  );

  bt_nmi_gen #(.CW(CW)) u_nmi (
    .clk       (clk),
    .rst_n     (srst_n),
    .flush     (flush),
    .dir       (dir_q),
    .depth     (depth),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .count_nxt (fifo_cnt_nxt),
    .para_acc  (para_acc),
    .nmi       (nmi_o)
  );

  assign h_rdata_o = s_rdata[SIDE_HOST];
  assign p_rdata_o = s_rdata[SIDE_PARA];

  // R4
  h_rw_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(h_sel_i && h_rd_i && h_wr_i));

  // R4
  p_rw_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(p_sel_i && p_rd_i && p_wr_i));

  // R4
  wrong_side_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!flush
     && !(h_sel_i && (h_ofs_i == OFS_DATA) && ((dir_q == DIR_H2P) ? h_wr_i : h_rd_i))
     && !(p_sel_i && (p_ofs_i == OFS_DATA) && ((dir_q == DIR_H2P) ? p_rd_i : p_wr_i)))
    |=> $stable(fifo_cnt));

endmodule

// File: tb/bt_xfer_chan_tb.sv
`timescale 1ns/1ps
module bt_xfer_chan_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wide, cfg_dir;
  logic       h_sel, h_ofs, h_rd, h_wr, p_sel, p_ofs, p_rd, p_wr;
  logic [7:0] h_wdata, p_wdata;
  logic [7:0] h_rdata, p_rdata;
  logic       nmi;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // behavioural reference state
  logic [7:0] q[$];
  bit         m_nmi, m_wide, m_dir;

  always #2 clk = ~clk;

  bt_xfer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wide_i(cfg_wide), .cfg_dir_i(cfg_dir),
    .h_sel_i(h_sel), .h_ofs_i(h_ofs), .h_rd_i(h_rd), .h_wr_i(h_wr),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .p_sel_i(p_sel), .p_ofs_i(p_ofs), .p_rd_i(p_rd), .p_wr_i(p_wr),
    .p_wdata_i(p_wdata), .p_rdata_o(p_rdata), .nmi_o(nmi)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input bit para);
    bit sel, ofs, rd, reader;
    int dep;
    sel = para ? p_sel : h_sel;
    ofs = para ? p_ofs : h_ofs;
    rd  = para ? p_rd  : h_rd;
    dep = m_wide ? 2 : 1;
    reader = (m_dir == 1'b0) ? para : !para;
    if (!(sel && rd)) return 8'h00;
    if (!ofs) return {q.size() != 0, q.size() < dep, 6'b0};
    if (reader && q.size() > 0) return q[0];
    return 8'h00;
  endfunction

  task automatic model_step();
    bit h_wd, h_rdd, p_wd, p_rdd, push, pop, do_push, do_pop, set;
    int dep, sz;
    logic [7:0] wd;
    if (cfg_wide != m_wide || cfg_dir != m_dir) begin
      q.delete();
      m_nmi  = 0;
      m_wide = cfg_wide;
      m_dir  = cfg_dir;
      return;
    end
    dep   = m_wide ? 2 : 1;
    h_wd  = h_sel && h_ofs && h_wr;
    h_rdd = h_sel && h_ofs && h_rd;
    p_wd  = p_sel && p_ofs && p_wr;
    p_rdd = p_sel && p_ofs && p_rd;
    push  = (m_dir == 1'b0) ? h_wd  : p_wd;
    pop   = (m_dir == 1'b0) ? p_rdd : h_rdd;
    wd    = (m_dir == 1'b0) ? h_wdata : p_wdata;
    sz    = q.size();
    do_pop  = pop  && (sz > 0);
    do_push = push && (sz < dep);
    if (do_pop)  void'(q.pop_front());
    if (do_push) q.push_back(wd);
    set = (m_dir == 1'b0) ? (do_push && q.size() == dep) : (do_pop && q.size() == 0);
    if (set) m_nmi = 1;
    else if (p_wd || p_rdd) m_nmi = 0;
  endtask

  // compare all outputs before the edge, then advance the model
  task automatic tick(input string tag);
    logic [7:0] eh, ep;
    #0.5;
    eh = exp_rd(1'b0);
    ep = exp_rd(1'b1);
    chk({tag, " host rdata"}, h_rdata, eh);
    chk({tag, " para rdata"}, p_rdata, ep);
    chk({tag, " nmi"}, {7'b0, nmi}, {7'b0, m_nmi});
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic drive(input bit hs, input bit ho, input bit hr, input bit hw, input logic [7:0] hd,
                       input bit ps, input bit po, input bit pr, input bit pw, input logic [7:0] pd);
    h_sel = hs; h_ofs = ho; h_rd = hr; h_wr = hw; h_wdata = hd;
    p_sel = ps; p_ofs = po; p_rd = pr; p_wr = pw; p_wdata = pd;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    q.delete(); m_nmi = 0; m_wide = 0; m_dir = 0;
    cfg_wide = 0; cfg_dir = 0; idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    #0.5 chk("R1 status", h_rdata, 8'h40);
    chk("R1 nmi", {7'b0, nmi}, 8'h00);
    tick("R1");

    // R6: narrow, host to parasite
    drive(1, 1, 0, 1, 8'hA5, 0, 0, 0, 0, 0); tick("R6");
    chk("R6 nmi set", {7'b0, nmi}, 8'h01);
    drive(0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    #0.5 chk("R2 full status", p_rdata, 8'h80);
    tick("R2");
    chk("R8 status read keeps nmi", {7'b0, nmi}, 8'h01);
    drive(0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    #0.5 chk("R5 data", p_rdata, 8'hA5);
    tick("R8");
    chk("R8 nmi cleared", {7'b0, nmi}, 8'h00);

    // R3 R9: switch to wide
    idle(); cfg_wide = 1; tick("R9");
    drive(1, 1, 0, 1, 8'h11, 0, 0, 0, 0, 0); tick("R3");
    chk("R6 no nmi at one of two", {7'b0, nmi}, 8'h00);
    drive(1, 1, 0, 1, 8'h22, 0, 0, 0, 0, 0); tick("R6");
    chk("R6 nmi at two", {7'b0, nmi}, 8'h01);
    drive(1, 1, 0, 1, 8'h33, 0, 0, 0, 0, 0); tick("R3");
    drive(0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    #0.5 chk("R5 order first", p_rdata, 8'h11);
    tick("R5");
    #0.5 chk("R5 order second", p_rdata, 8'h22);
    tick("R5");
    #0.5 chk("R3 dropped byte absent", p_rdata, 8'h00);
    tick("R3");

    // R4: wrong-side write and read
    drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 8'h77); tick("R4");
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    #0.5 chk("R4 wrong write ignored", h_rdata, 8'h40);
    tick("R4");
    drive(1, 1, 0, 1, 8'h44, 0, 0, 0, 0, 0); tick("R4");
    drive(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    #0.5 chk("R4 writer read zero", h_rdata, 8'h00);
    tick("R4");

    // R10: simultaneous write and read
    drive(1, 1, 0, 1, 8'h55, 1, 1, 1, 0, 0);
    #0.5 chk("R10 read head", p_rdata, 8'h44);
    tick("R10");
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    #0.5 chk("R10 one byte held", h_rdata, 8'hC0);
    tick("R10");
    drive(0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    #0.5 chk("R10 new byte", p_rdata, 8'h55);
    tick("R10");

    // R7: parasite to host
    idle(); cfg_dir = 1; tick("R9");
    drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 8'h61); tick("R7");
    drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 8'h62); tick("R7");
    drive(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    #0.5 chk("R7 first", h_rdata, 8'h61);
    tick("R7");
    chk("R7 no nmi half", {7'b0, nmi}, 8'h00);
    #0.5 chk("R7 second", h_rdata, 8'h62);
    tick("R7");
    chk("R7 nmi on empty", {7'b0, nmi}, 8'h01);
    drive(0, 0, 0, 0, 0, 1, 0, 1, 0, 0); tick("R8");
    chk("R8 status keeps nmi", {7'b0, nmi}, 8'h01);
    drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 8'h63); tick("R8");
    chk("R8 write clears", {7'b0, nmi}, 8'h00);
    drive(1, 1, 1, 0, 0, 0, 0, 0, 0, 0); tick("R7");
    chk("R7 nmi again", {7'b0, nmi}, 8'h01);

    // R9: flush clears nmi and held data, ignores accesses
    idle(); cfg_wide = 0; tick("R9");
    chk("R9 nmi cleared", {7'b0, nmi}, 8'h00);
    drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 8'h65); tick("R9");
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0); cfg_dir = 0; tick("R9");
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    #0.5 chk("R9 flushed", h_rdata, 8'h40);
    tick("R9");
    drive(1, 1, 0, 1, 8'h99, 0, 0, 0, 0, 0); cfg_dir = 1; tick("R9");
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    #0.5 chk("R9 access in flush ignored", h_rdata, 8'h40);
    tick("R9");

    // R2 R5: random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int hop, pop_sel;
      hop = $urandom_range(0, 5);
      pop_sel = $urandom_range(0, 5);
      drive(hop != 0, hop > 1, hop == 2 || hop == 4, hop == 3 || hop == 5, 8'($urandom),
            pop_sel != 0, pop_sel > 1, pop_sel == 2 || pop_sel == 4, pop_sel == 3 || pop_sel == 5,
            8'($urandom));
      if ($urandom_range(0, 99) == 0) cfg_wide = ~cfg_wide;
      if ($urandom_range(0, 149) == 0) cfg_dir = ~cfg_dir;
      tick("R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule